// File: doc/BRIEF.md
# PWM Period Reconfiguration Sequencer

This block sits next to a shared-counter PWM timer and carries out a change of the timer period. A request gives the new period as a count of undivided input-clock ticks together with a six-bit mask of the channels in use. The sequencer picks the smallest power-of-two prescaler for which the period still fits the 16-bit counter. It then derives the new modulus and reads the timer's current setting. When nothing would change, it stops there.

Otherwise it halts the counter and waits until the halt reads back. It then rescales the compare value of every active channel so that each duty cycle survives the new modulus, using an integer multiply and a bit-serial divide. Last, it clears the counter, loads the modulus and restarts the counter with the chosen prescaler. All timer access goes through a single-cycle register port. `busy` covers the whole sequence, and `done` marks its end.

Top module: `pwm_period_seq`

## Requirements
- R1: The prescale exponent e is the smallest value in 0..7 for which 65535·2^e is not below the clamped request. If no such value exists, e is 7.
- R2: The new modulus is (clamped request >> e) − 1. It is written to address 2, the modulus register.
- R3: Two reads come first: address 0, the control register, and address 2. The control register has the clock mode in bits [4:3] and the prescale exponent in bits [2:0]. If the current modulus equals the new one and the clock mode reads 01, no register is written.
- R4: Before anything else is written, the control register is written with bits [4:0] cleared and is then read back. This pair repeats until bits [4:0] read zero.
- R5: For each channel n whose mask bit is set, the compare register at address 3+n is read. The new value is old·(new modulus+1)/(old modulus+1), truncated. It saturates to new modulus+1, and then to 65535.
- R6: A compare register is written only when its mask bit is set and the rescaled value differs from the value read.
- R7: The sequence ends with three writes in this order: 0 to the counter (address 1), the new modulus, and then the control register. The last write holds clock mode 01, the chosen exponent, and the bits above bit 4 as they were read.
- R8: A request below 2 ticks is treated as 2. A request above 8388608 ticks is treated as 8388608.
- R9: `busy` is high from the cycle after a request is accepted until the sequence ends. A request presented while `busy` is high is ignored.
- R10: `done` is high for exactly one cycle after each accepted request, whether the sequence was carried out or skipped. `busy` is low while `done` is high.
- R11: The register port is idle while `busy` is low, and it never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_ticks | input | 24 | Requested period in undivided input-clock ticks |
| req_mask | input | 6 | Active-channel mask |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_wr | output | 1 | Timer register write strobe |
| reg_rd | output | 1 | Timer register read strobe |
| reg_addr | output | 4 | Timer register address |
| reg_wdata | output | 16 | Timer register write data |
| reg_rdata | input | 16 | Timer register read data for reg_addr, same cycle |

## Verification
The retry loop that waits for the halt to take effect is the hardest case to reach. A real timer clears its mode bits at once, so the loop never runs. The bench's timer model can be told to ignore a given number of clearing writes to the control register. With that set to two, the bench expects four control writes in place of two, and it checks that the upper control bits come back unchanged. The saturation paths need an inconsistent starting state: a compare value above the old period, and a rescaled value of 65536. The bench preloads the model with such values directly.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

    localparam int DATA_W   = 16;
    localparam int PER_W    = 24;
    localparam int CH_N     = 6;
    localparam int ADDR_W   = 4;
    localparam int PS_BITS  = 3;
    localparam int PS_MAX   = 7;
    localparam int MODE_LSB = 3;
    localparam int IDX_W    = $clog2(CH_N + 1);
    localparam int DEN_W    = DATA_W + 1;
    localparam int NUM_W    = DATA_W + DEN_W;

    localparam logic [1:0]        MODE_RUN = 2'b01;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT    = 4'd1;
    localparam logic [ADDR_W-1:0] A_MOD    = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMP0   = 4'd3;

    // mask of the mode and prescale field in the control register
    localparam logic [DATA_W-1:0] CFG_FIELD = 16'h001F;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CTRL,
        S_RD_MOD,
        S_CHECK,
        S_STOP_WR,
        S_STOP_RD,
        S_CH_NEXT,
        S_CH_RD,
        S_DIV,
        S_CH_WR,
        S_CNT_WR,
        S_MOD_WR,
        S_RUN_WR
    } seq_state_t;

    typedef struct packed {
        logic [PS_BITS-1:0] ps;
        logic [DATA_W-1:0]  modulus;
    } period_cfg_t;

    // control word that restarts the counter with a given exponent
    function automatic logic [DATA_W-1:0] run_word(
        input logic [DATA_W-1:0]  keep,
        input logic [PS_BITS-1:0] ps
    );
        logic [DATA_W-1:0] w;
        w = keep & ~CFG_FIELD;
        w[MODE_LSB +: 2] = MODE_RUN;
        w[PS_BITS-1:0]   = ps;
        return w;
    endfunction

endpackage

// File: rtl/pwm_period_calc.sv
module pwm_period_calc #(
    parameter int PER_W   = 24,
    parameter int DATA_W  = 16,
    parameter int PS_BITS = 3,
    parameter int PS_MAX  = 7
) (
    input  logic [PER_W-1:0]   ticks_i,
    output logic [PS_BITS-1:0] ps_o,
    output logic [DATA_W-1:0]  mod_o
);
    localparam logic [PER_W-1:0] T_MIN = PER_W'(2);
    localparam logic [PER_W-1:0] T_MAX = PER_W'(1) << (DATA_W + PS_MAX);

    logic [PER_W-1:0]   t;
    logic [PER_W:0]     lim;
    logic [PER_W-1:0]   scaled;
    logic [PS_BITS-1:0] e;

    always_comb begin
        t = ticks_i;
        if (t < T_MIN) t = T_MIN;
        if (t > T_MAX) t = T_MAX;
        e = '0;
        for (int i = 0; i < PS_MAX; i++) begin
            lim = {{(PER_W + 1 - DATA_W){1'b0}}, {DATA_W{1'b1}}} << i;
            if (int'(e) == i && lim < {1'b0, t}) e = PS_BITS'(i + 1);
        end
        scaled = t >> e;
        ps_o   = e;
        mod_o  = scaled[DATA_W-1:0] - DATA_W'(1);
    end
endmodule

// File: rtl/pwm_chan_pick.sv
module pwm_chan_pick #(
    parameter int CH_N  = 6,
    parameter int IDX_W = 3
) (
    input  logic [CH_N-1:0]  mask_i,
    input  logic [IDX_W-1:0] from_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (!found_o && i >= int'(from_i) && mask_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pwm_seq_div.sv
module pwm_seq_div #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             valid_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem_q, shifted, rem_n;
    logic [NUM_W-1:0] quo_q, quo_n;
    logic [DEN_W-1:0] den_q;
    logic [CW-1:0]    cnt_q;
    logic             run_q;

    always_comb begin
        shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
        quo_n   = {quo_q[NUM_W-2:0], 1'b0};
        rem_n   = shifted;
        if (shifted >= {1'b0, den_q}) begin
            rem_n    = shifted - {1'b0, den_q};
            quo_n[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                quo_q <= num_i;
                den_q <= den_i;
                cnt_q <= CW'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_n;
                quo_q <= quo_n;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q   <= 1'b0;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;
endmodule

// File: rtl/pwm_period_seq.sv
module pwm_period_seq
    import pwm_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PER_W-1:0]  req_ticks,
    input  logic [CH_N-1:0]   req_mask,
    output logic              busy,
    output logic              done,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    seq_state_t        state_q;
    period_cfg_t       calc_cfg, cfg_q;
    logic [CH_N-1:0]   mask_q;
    logic [DATA_W-1:0] ctrl_q, old_mod_q, old_cmp_q, new_cmp_q;
    logic [IDX_W-1:0]  idx_q;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic              div_start, div_valid;
    logic [NUM_W-1:0]  div_num, div_quo;
    logic [DEN_W-1:0]  div_den, new_span;
    logic [DATA_W-1:0] cmp_sat;
    logic [DEN_W-1:0]  span_sat;

    pwm_period_calc #(
        .PER_W(PER_W), .DATA_W(DATA_W), .PS_BITS(PS_BITS), .PS_MAX(PS_MAX)
    ) u_calc (
        .ticks_i(req_ticks),
        .ps_o   (calc_cfg.ps),
        .mod_o  (calc_cfg.modulus)
    );

    pwm_chan_pick #(.CH_N(CH_N), .IDX_W(IDX_W)) u_pick (
        .mask_i (mask_q),
        .from_i (idx_q),
        .found_o(pick_found),
        .idx_o  (pick_idx)
    );

    assign new_span  = {1'b0, cfg_q.modulus} + DEN_W'(1);
    assign div_den   = {1'b0, old_mod_q} + DEN_W'(1);
    assign div_num   = NUM_W'(reg_rdata) * NUM_W'(new_span);
    assign div_start = (state_q == S_CH_RD);

    pwm_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .start_i(div_start),
        .num_i  (div_num),
        .den_i  (div_den),
        .valid_o(div_valid),
        .quo_o  (div_quo)
    );

    // clamp to the new span, then to the register width
    always_comb begin
        if (div_quo > NUM_W'(new_span)) span_sat = new_span;
        else                            span_sat = div_quo[DEN_W-1:0];
        if (span_sat[DATA_W]) cmp_sat = {DATA_W{1'b1}};
        else                  cmp_sat = span_sat[DATA_W-1:0];
    end

    // register port decode
    always_comb begin
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_addr  = A_CTRL;
        reg_wdata = '0;
        unique case (state_q)
            S_RD_CTRL: reg_rd = 1'b1;
            S_RD_MOD: begin
                reg_rd   = 1'b1;
                reg_addr = A_MOD;
            end
            S_STOP_WR: begin
                reg_wr    = 1'b1;
                reg_wdata = ctrl_q & ~CFG_FIELD;
            end
            S_STOP_RD: reg_rd = 1'b1;
            S_CH_RD: begin
                reg_rd   = 1'b1;
                reg_addr = A_CMP0 + ADDR_W'(idx_q);
            end
            S_CH_WR: begin
                reg_wr    = (new_cmp_q != old_cmp_q);
                reg_addr  = A_CMP0 + ADDR_W'(idx_q);
                reg_wdata = new_cmp_q;
            end
            S_CNT_WR: begin
                reg_wr   = 1'b1;
                reg_addr = A_CNT;
            end
            S_MOD_WR: begin
                reg_wr    = 1'b1;
                reg_addr  = A_MOD;
                reg_wdata = cfg_q.modulus;
            end
            S_RUN_WR: begin
                reg_wr    = 1'b1;
                reg_wdata = run_word(ctrl_q, cfg_q.ps);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            cfg_q     <= '0;
            mask_q    <= '0;
            ctrl_q    <= '0;
            old_mod_q <= '0;
            old_cmp_q <= '0;
            new_cmp_q <= '0;
            idx_q     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    cfg_q   <= calc_cfg;
                    mask_q  <= req_mask;
                    state_q <= S_RD_CTRL;
                end
                S_RD_CTRL: begin
                    ctrl_q  <= reg_rdata;
                    state_q <= S_RD_MOD;
                end
                S_RD_MOD: begin
                    old_mod_q <= reg_rdata;
                    state_q   <= S_CHECK;
                end
                S_CHECK: begin
                    if (old_mod_q == cfg_q.modulus &&
                        ctrl_q[MODE_LSB +: 2] == MODE_RUN) begin
                        done    <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        state_q <= S_STOP_WR;
                    end
                end
                S_STOP_WR: state_q <= S_STOP_RD;
                S_STOP_RD: begin
                    if ((reg_rdata & CFG_FIELD) == '0) begin
                        idx_q   <= '0;
                        state_q <= S_CH_NEXT;
                    end else begin
                        state_q <= S_STOP_WR;
                    end
                end
                S_CH_NEXT: begin
                    if (pick_found) begin
                        idx_q   <= pick_idx;
                        state_q <= S_CH_RD;
                    end else begin
                        state_q <= S_CNT_WR;
                    end
                end
                S_CH_RD: begin
                    old_cmp_q <= reg_rdata;
                    state_q   <= S_DIV;
                end
                S_DIV: if (div_valid) begin
                    new_cmp_q <= cmp_sat;
                    state_q   <= S_CH_WR;
                end
                S_CH_WR: begin
                    idx_q   <= idx_q + IDX_W'(1);
                    state_q <= S_CH_NEXT;
                end
                S_CNT_WR: state_q <= S_MOD_WR;
                S_MOD_WR: state_q <= S_RUN_WR;
                S_RUN_WR: begin
                    done    <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/pwm_period_seq_chk.sv
module pwm_period_seq_chk
    import pwm_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!reg_wr && !reg_rd));

    // R11
    access_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R4
    stop_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && (reg_wdata & CFG_FIELD) == '0)
        |=> (reg_rd && reg_addr == A_CTRL));

    // R7
    cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CNT) |-> reg_wdata == '0);

    // R7
    cnt_then_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CNT) |=> (reg_wr && reg_addr == A_MOD));

    // R7
    mod_then_run_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_MOD)
        |=> (reg_wr && reg_addr == A_CTRL && reg_wdata[MODE_LSB +: 2] == MODE_RUN));

    // R7
    run_last_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CTRL && reg_wdata[MODE_LSB +: 2] == MODE_RUN) |=> done);
endmodule

bind pwm_period_seq pwm_period_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/pwm_period_seq_test.sv
module pwm_period_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_ticks = '0;
    logic [5:0]  req_mask = '0;
    logic        busy, done, reg_wr, reg_rd;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // timer model
    logic [15:0] m_ctrl, m_cnt, m_mod;
    logic [15:0] m_cmp [6];
    int          wr_cnt [9];
    int          wr_total;
    int          hist [3];
    int          stuck;
    int          idle_acc;

    always #10 clk = ~clk;

    pwm_period_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ticks(req_ticks),
        .req_mask(req_mask), .busy(busy), .done(done), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always_comb begin
        case (reg_addr)
            4'd0:    reg_rdata = m_ctrl;
            4'd1:    reg_rdata = m_cnt;
            4'd2:    reg_rdata = m_mod;
            4'd3:    reg_rdata = m_cmp[0];
            4'd4:    reg_rdata = m_cmp[1];
            4'd5:    reg_rdata = m_cmp[2];
            4'd6:    reg_rdata = m_cmp[3];
            4'd7:    reg_rdata = m_cmp[4];
            4'd8:    reg_rdata = m_cmp[5];
            default: reg_rdata = 16'hDEAD;
        endcase
    end

    always @(posedge clk) begin
        if (reg_wr && reg_addr < 4'd9) begin
            wr_cnt[reg_addr] = wr_cnt[reg_addr] + 1;
            wr_total = wr_total + 1;
            hist[0] = hist[1];
            hist[1] = hist[2];
            hist[2] = int'(reg_addr);
            case (reg_addr)
                4'd0: begin
                    if (stuck > 0 && reg_wdata[4:0] == 5'd0) stuck = stuck - 1;
                    else m_ctrl = reg_wdata;
                end
                4'd1: m_cnt = reg_wdata;
                4'd2: m_mod = reg_wdata;
                default: m_cmp[reg_addr - 4'd3] = reg_wdata;
            endcase
        end
    end

    always @(negedge clk) if (!rst && !busy && (reg_wr || reg_rd)) idle_acc = idle_acc + 1;

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampt(input longint p);
        if (p < 2) return 2;
        if (p > 8388608) return 8388608;
        return int'(p);
    endfunction

    function automatic int exp_ps(input longint p);
        int t = clampt(p);
        int e = 0;
        while (e < 7 && (longint'(65535) << e) < t) e++;
        return e;
    endfunction

    function automatic int exp_mod(input longint p);
        return ((clampt(p) >> exp_ps(p)) - 1) & 16'hFFFF;
    endfunction

    function automatic int exp_cmp(input int c, input int om, input int nm);
        longint q = (longint'(c) * (nm + 1)) / (om + 1);
        if (q > nm + 1) q = nm + 1;
        if (q > 65535) q = 65535;
        return int'(q);
    endfunction

    task automatic setup(input int ctrl, input int md, input int c0, input int c1, input int c2);
        @(negedge clk);
        m_ctrl = 16'(ctrl); m_mod = 16'(md); m_cnt = 16'd777;
        m_cmp[0] = 16'(c0); m_cmp[1] = 16'(c1); m_cmp[2] = 16'(c2);
        m_cmp[3] = 16'd0; m_cmp[4] = 16'd0; m_cmp[5] = 16'd0;
        for (int i = 0; i < 9; i++) wr_cnt[i] = 0;
        wr_total = 0; hist[0] = -1; hist[1] = -1; hist[2] = -1;
        stuck = 0;
    endtask

    // issue a request, check busy, done pulse width (R9, R10)
    task automatic run_req(input int ticks, input logic [5:0] mask);
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_ticks = 24'(ticks); req_mask = mask;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after accept", busy == 1'b1, busy, 1);
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R10 done seen", done == 1'b1, done, 1);
        chk("R10 busy low with done", busy == 1'b0, busy, 0);
        @(negedge clk);
        chk("R10 done one cycle", done == 1'b0, done, 0);
    endtask

    task automatic t_reset;
        chk("R10 reset done", done == 1'b0, done, 0);
        chk("R9 reset busy", busy == 1'b0, busy, 0);
        chk("R11 reset port idle", !reg_wr && !reg_rd, reg_wr, 0);
    endtask

    task automatic t_basic;
        int nm = exp_mod(4000);
        setup(16'h08, 999, 500, 123, 250);
        run_req(4000, 6'b000101);
        chk("R2 modulus", m_mod == 16'(nm), m_mod, nm);
        chk("R1 control ps0", m_ctrl == 16'h08, m_ctrl, 16'h08);
        chk("R5 ch0 rescale", m_cmp[0] == 16'(exp_cmp(500, 999, nm)), m_cmp[0], exp_cmp(500, 999, nm));
        chk("R5 ch2 rescale", m_cmp[2] == 16'(exp_cmp(250, 999, nm)), m_cmp[2], exp_cmp(250, 999, nm));
        chk("R6 unmasked ch1 untouched", wr_cnt[4] == 0 && m_cmp[1] == 16'd123, wr_cnt[4], 0);
        chk("R7 counter cleared", m_cnt == 16'd0, m_cnt, 0);
        chk("R7 order cnt", hist[0] == 1, hist[0], 1);
        chk("R7 order mod", hist[1] == 2, hist[1], 2);
        chk("R7 order ctrl", hist[2] == 0, hist[2], 0);
    endtask

    task automatic t_prescale;
        int nm = exp_mod(200000);
        setup(16'h08, 3999, 2000, 0, 0);
        run_req(200000, 6'b000001);
        chk("R1 exponent 2", m_ctrl == 16'(8 + exp_ps(200000)), m_ctrl, 8 + exp_ps(200000));
        chk("R2 modulus 49999", m_mod == 16'(nm) && nm == 49999, m_mod, nm);
        chk("R5 ch0 prescaled", m_cmp[0] == 16'(exp_cmp(2000, 3999, nm)), m_cmp[0], exp_cmp(2000, 3999, nm));
    endtask

    task automatic t_skip;
        setup(16'h0A, 49999, 100, 0, 0);
        run_req(200000, 6'b000001);
        chk("R3 skip no writes", wr_total == 0, wr_total, 0);
        setup(16'h00, 3999, 100, 0, 0);
        run_req(4000, 6'b000001);
        chk("R3 stopped counter reprogrammed", m_ctrl == 16'h08, m_ctrl, 16'h08);
    endtask

    task automatic t_stop_retry;
        setup(16'h48, 999, 0, 0, 0);
        stuck = 2;
        run_req(3000, 6'b000000);
        chk("R4 stop retries", wr_cnt[0] == 4, wr_cnt[0], 4);
        chk("R7 upper bits kept", m_ctrl == 16'h48, m_ctrl, 16'h48);
        chk("R2 modulus after retry", m_mod == 16'd2999, m_mod, 2999);
    endtask

    task automatic t_clamp;
        setup(16'h08, 999, 0, 0, 0);
        run_req(1, 6'b000000);
        chk("R8 low clamp", m_mod == 16'd1, m_mod, 1);
        setup(16'h08, 999, 0, 0, 0);
        run_req(0, 6'b000000);
        chk("R8 zero clamp", m_mod == 16'd1, m_mod, 1);
        setup(16'h08, 999, 0, 0, 0);
        run_req(24'hFFFFFF, 6'b000000);
        chk("R8 high clamp mod", m_mod == 16'hFFFF, m_mod, 65535);
        chk("R1 exponent 7", m_ctrl == 16'h0F, m_ctrl, 16'h0F);
    endtask

    task automatic t_saturate;
        setup(16'h08, 99, 300, 50, 200);
        run_req(1000, 6'b000011);
        chk("R5 saturate to span", m_cmp[0] == 16'd1000, m_cmp[0], 1000);
        chk("R5 ch1 normal", m_cmp[1] == 16'd500, m_cmp[1], 500);
        setup(16'h08, 99, 0, 0, 200);
        run_req(24'h800000, 6'b000101);
        chk("R5 cap 65535", m_cmp[2] == 16'hFFFF, m_cmp[2], 65535);
        chk("R6 equal value not written", wr_cnt[3] == 0, wr_cnt[3], 0);
    endtask

    task automatic t_busy_ignore;
        int n = 0;
        setup(16'h08, 999, 0, 0, 0);
        @(negedge clk);
        req_valid = 1'b1; req_ticks = 24'd5000; req_mask = 6'd0;
        @(negedge clk);
        req_ticks = 24'd7000;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk("R9 request while busy ignored", m_mod == 16'd4999, m_mod, 4999);
        chk("R9 back to idle", busy == 1'b0, busy, 0);
    endtask

    initial begin
        idle_acc = 0;
        setup(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_prescale();
        t_skip();
        t_stop_retry();
        t_clamp();
        t_saturate();
        t_busy_ignore();
        chk("R11 port idle while not busy", idle_acc == 0, idle_acc, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule